// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions in a speculative out-of-order core. When an instruction is dispatched, the block takes the next free slot at the tail of a circular buffer. It returns that slot number as the rename tag. Functional units finish in any order and broadcast their results on a result bus together with the tag. The block stores each value in the slot the tag names and marks that slot complete.

Retirement happens only at the head, one entry per cycle, and only once the head entry is complete. A register operation retires as a register-file write of its register number and value. A store retires as a memory write of its address and data. A branch retires with no write. If the retiring branch was flagged as mispredicted, every younger entry is discarded, the buffer returns to its reset state, and a redirect carries the correct successor address, which is the value the branch produced.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty and not full. No commit, write strobe or redirect is asserted, dispatch is ready, and the next tag is 0.
- R2: Each accepted dispatch is given the current tail slot as its tag. Tags advance by one and wrap from DEPTH-1 to 0. Once DEPTH entries are held, `full` is high and `issueReady` is low.
- R3: A result-bus write sets the value of the slot named by `resTag` and marks it complete. A write to a slot that holds no instruction is ignored: an instruction later given that slot does not retire until its own result arrives.
- R4: Only the head entry retires, and only when it is complete. Entries retire in dispatch order whatever order their results arrive in, and at most one retires per cycle.
- R5: Kind encoding is 0 for a register operation, 1 for a store and 2 for a branch. When a register operation retires, `regWe` is high and `regAddr`/`regData` carry its destination and value. `memWe` stays low.
- R6: When a store retires, `memWe` is high and `memAddr`/`memData` carry its destination address and value. `regWe` stays low.
- R7: A branch that was not mispredicted retires with `commitValid` high, both write strobes low and `redirectValid` low.
- R8: When a branch whose result carried `resMispred` retires, `redirectValid` is high and `redirectPc` equals the branch value. `issueReady` is low in that cycle. In the next cycle the buffer is empty, the next tag is 0, and no younger entry ever retires.
- R9: A slot freed by retirement can be used again. When one entry retires from a full buffer, `full` drops in the next cycle and the next dispatch receives the freed slot.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Dispatch request |
| issueKind | input | 2 | Instruction kind (0 reg, 1 store, 2 branch) |
| issueDest | input | DEST_W | Register number or store address |
| issueReady | output | 1 | Dispatch accepted this cycle if requested |
| issueTag | output | IDX_W | Tag given to the dispatch |
| robFull | output | 1 | All slots occupied |
| robEmpty | output | 1 | No slot occupied |
| resValid | input | 1 | Result-bus write |
| resTag | input | IDX_W | Slot targeted by the result |
| resValue | input | DATA_W | Result value (branch: correct successor) |
| resMispred | input | 1 | Branch result was mispredicted |
| commitValid | output | 1 | Head entry retires this cycle |
| commitKind | output | 2 | Kind of retiring entry |
| commitDest | output | DEST_W | Destination of retiring entry |
| commitValue | output | DATA_W | Value of retiring entry |
| regWe | output | 1 | Register-file write strobe |
| regAddr | output | DEST_W | Register number written |
| regData | output | DATA_W | Register value written |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | DEST_W | Store address |
| memData | output | DATA_W | Store data |
| redirectValid | output | 1 | Flush and fetch restart |
| redirectPc | output | DATA_W | Restart address |

## Verification
Assertions check on every cycle that the occupancy count matches the number of busy slots and never exceeds the depth. They also check that dispatch only lands on a free slot, that the head advances after a retirement, that a result write marks its slot complete, that a flush leaves an empty buffer, and that the two write strobes are never high together. Retirement order, the field values seen at retirement, tag wrap-around, the ignored stray result and the discarding of younger entries after a mispredicted branch can only be shown by the bench's scenarios, which compare every retirement with a queue of expected entries.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    OP_REG    = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2
  } opKind_e;

  typedef struct packed {
    logic alloc;   // write a new entry at the tail
    logic resWr;   // write a result by tag
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             resValid,
  input  logic [IDX_W-1:0] resTag,
  input  opKind_e          headKind,
  input  logic             headMispred,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             issueReady,
  output logic             robFull,
  output logic             robEmpty,
  output logic             commitValid,
  output logic             flushValid
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ;
  logic [DEPTH-1:0] busyQ, doneQ;
  logic             doIssue, tagOk;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    tagOk         = (int'(resTag) < DEPTH);
    commitValid   = busyQ[headQ] && doneQ[headQ];
    flushValid    = commitValid && (headKind == OP_BRANCH) && headMispred;
    robFull       = (countQ == CNT_W'(DEPTH));
    robEmpty      = (countQ == '0);
    issueReady    = !robFull && !flushValid;
    doIssue       = issueValid && issueReady;
    strobe.alloc  = doIssue;
    strobe.resWr  = resValid && tagOk && busyQ[resTag] && !flushValid;
    headIdx       = headQ;
    tailIdx       = tailQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flushValid) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
      busyQ  <= '0;
      doneQ  <= '0;
    end else begin
      if (strobe.resWr) doneQ[resTag] <= 1'b1;
      if (commitValid) begin
        busyQ[headQ] <= 1'b0;
        doneQ[headQ] <= 1'b0;
        headQ        <= stepIdx(headQ);
      end
      if (doIssue) begin
        busyQ[tailQ] <= 1'b1;
        doneQ[tailQ] <= 1'b0;
        tailQ        <= stepIdx(tailQ);
      end
      countQ <= countQ + CNT_W'(doIssue) - CNT_W'(commitValid);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH)); // R2
  AST_COUNT_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busyQ) == int'(countQ)); // R9
  AST_ISSUE_TO_FREE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    doIssue |-> !busyQ[tailQ]); // R2
  AST_HEAD_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !flushValid && DEPTH > 1) |=> (headQ != $past(headQ))); // R4
  AST_RESULT_MARKS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.resWr && !(commitValid && resTag == headQ)) |=> doneQ[$past(resTag)]); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (robEmpty && !commitValid)); // R8
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int DEST_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strobe,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  opKind_e           issueKind,
  input  logic [DEST_W-1:0] issueDest,
  input  logic [IDX_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resValue,
  input  logic              resMispred,
  output opKind_e           headKind,
  output logic [DEST_W-1:0] headDest,
  output logic [DATA_W-1:0] headValue,
  output logic              headMispred
);
  opKind_e           kindQ [DEPTH];
  logic [DEST_W-1:0] destQ [DEPTH];
  logic [DATA_W-1:0] valQ  [DEPTH];
  logic [DEPTH-1:0]  mispQ;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        kindQ[g]  <= OP_REG;
        destQ[g]  <= '0;
        valQ[g]   <= '0;
        mispQ[g]  <= 1'b0;
      end else begin
        if (strobe.alloc && int'(tailIdx) == g) begin
          kindQ[g] <= issueKind;
          destQ[g] <= issueDest;
          mispQ[g] <= 1'b0;
        end
        if (strobe.resWr && int'(resTag) == g) begin
          valQ[g]  <= resValue;
          mispQ[g] <= resMispred;
        end
      end
    end
  end

  always_comb begin
    headKind    = kindQ[headIdx];
    headDest    = destQ[headIdx];
    headValue   = valQ[headIdx];
    headMispred = mispQ[headIdx];
  end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [DEST_W-1:0] issueDest,
  output logic              issueReady,
  output logic [IDX_W-1:0]  issueTag,
  output logic              robFull,
  output logic              robEmpty,
  input  logic              resValid,
  input  logic [IDX_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resValue,
  input  logic              resMispred,
  output logic              commitValid,
  output logic [1:0]        commitKind,
  output logic [DEST_W-1:0] commitDest,
  output logic [DATA_W-1:0] commitValue,
  output logic              regWe,
  output logic [DEST_W-1:0] regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              memWe,
  output logic [DEST_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              redirectValid,
  output logic [DATA_W-1:0] redirectPc
);
  robStrobe_t        strobe;
  logic [IDX_W-1:0]  headIdx, tailIdx;
  opKind_e           headKind;
  logic [DEST_W-1:0] headDest;
  logic [DATA_W-1:0] headValue;
  logic              headMispred, flushValid;

  rob_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .resValid(resValid), .resTag(resTag),
    .headKind(headKind), .headMispred(headMispred),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .issueReady(issueReady), .robFull(robFull), .robEmpty(robEmpty),
    .commitValid(commitValid), .flushValid(flushValid)
  );

  rob_data #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tailIdx(tailIdx), .headIdx(headIdx),
    .issueKind(opKind_e'(issueKind)), .issueDest(issueDest),
    .resTag(resTag), .resValue(resValue), .resMispred(resMispred),
    .headKind(headKind), .headDest(headDest),
    .headValue(headValue), .headMispred(headMispred)
  );

  always_comb begin
    issueTag      = tailIdx;
    commitKind    = headKind;
    commitDest    = headDest;
    commitValue   = headValue;
    regWe         = commitValid && (headKind == OP_REG);
    regAddr       = headDest;
    regData       = headValue;
    memWe         = commitValid && (headKind == OP_STORE);
    memAddr       = headDest;
    memData       = headValue;
    redirectValid = flushValid;
    redirectPc    = headValue;
  end

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && memWe)); // R5
  AST_STROBE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (regWe || memWe || redirectValid) |-> commitValid); // R4
endmodule

// File: tb/reorder_buffer_tb.sv
module reorder_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int DEST_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [1:0] issueKind = '0;
  logic [DEST_W-1:0] issueDest = '0;
  logic issueReady, robFull, robEmpty;
  logic [IDX_W-1:0] issueTag;
  logic resValid = 1'b0;
  logic [IDX_W-1:0] resTag = '0;
  logic [DATA_W-1:0] resValue = '0;
  logic resMispred = 1'b0;
  logic commitValid, regWe, memWe, redirectValid;
  logic [1:0] commitKind;
  logic [DEST_W-1:0] commitDest, regAddr, memAddr;
  logic [DATA_W-1:0] commitValue, regData, memData, redirectPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueKind(issueKind),
    .issueDest(issueDest), .issueReady(issueReady), .issueTag(issueTag),
    .robFull(robFull), .robEmpty(robEmpty), .resValid(resValid),
    .resTag(resTag), .resValue(resValue), .resMispred(resMispred),
    .commitValid(commitValid), .commitKind(commitKind), .commitDest(commitDest),
    .commitValue(commitValue), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  typedef struct {
    logic [1:0]        kind;
    logic [DEST_W-1:0] dest;
    logic [DATA_W-1:0] value;
    bit                misp;
  } exp_t;

  exp_t sb[$];
  logic [DATA_W-1:0] valByTag [DEPTH];
  bit                mispByTag [DEPTH];
  int checks = 0;
  int errors = 0;
  int expTail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: dispatch one instruction and push its expected retirement
  task automatic issue(input logic [1:0] kind, input logic [DEST_W-1:0] dest,
                       input logic [DATA_W-1:0] value, input bit misp,
                       output logic [IDX_W-1:0] tag);
    exp_t e;
    @(negedge clk);
    while (!issueReady) @(negedge clk);
    chk(int'(issueTag) == expTail, "R2 tag order", issueTag, expTail);
    tag = issueTag;
    valByTag[tag]  = value;
    mispByTag[tag] = misp;
    e.kind = kind; e.dest = dest; e.value = value; e.misp = misp;
    sb.push_back(e);
    issueValid = 1'b1; issueKind = kind; issueDest = dest;
    @(posedge clk); #1;
    issueValid = 1'b0;
    expTail = (expTail + 1) % DEPTH;
  endtask

  task automatic result(input logic [IDX_W-1:0] tag, input logic [DATA_W-1:0] value,
                        input bit misp);
    @(negedge clk);
    resValid = 1'b1; resTag = tag; resValue = value; resMispred = misp;
    @(posedge clk); #1;
    resValid = 1'b0; resMispred = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
    chk(sb.size() == 0, "R4 all retired", sb.size(), 0);
  endtask

  // Monitor: every retirement must match the head of the expected queue (R4)
  always @(negedge clk) begin
    if (rstN && commitValid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected retirement", commitDest, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(commitKind == e.kind, "R4 kind", commitKind, e.kind);
        chk(commitDest == e.dest, "R4 dest", commitDest, e.dest);
        chk(commitValue == e.value, "R4 value", commitValue, e.value);
        chk(regWe == (e.kind == 2'd0), "R5 regWe", regWe, e.kind == 2'd0);
        chk(memWe == (e.kind == 2'd1), "R6 memWe", memWe, e.kind == 2'd1);
        if (e.kind == 2'd0)
          chk(regAddr == e.dest && regData == e.value, "R5 reg port", regData, e.value);
        if (e.kind == 2'd1)
          chk(memAddr == e.dest && memData == e.value, "R6 mem port", memData, e.value);
        chk(redirectValid == e.misp, "R7 redirect", redirectValid, e.misp);
        if (e.misp) begin
          chk(redirectPc == e.value, "R8 redirectPc", redirectPc, e.value);
          chk(!issueReady, "R8 issue blocked", issueReady, 0);
          sb.delete();
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [IDX_W-1:0] t0, t1, t2, tx, tb, tg [DEPTH];
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(robEmpty && !robFull, "R1 empty", {robEmpty, robFull}, 2'b10);
    chk(!commitValid && !regWe && !memWe && !redirectValid, "R1 quiet",
        {commitValid, regWe, memWe, redirectValid}, 0);
    chk(issueReady && issueTag == 0, "R1 ready tag0", issueTag, 0);

    // R4 out-of-order completion retires in order
    issue(2'd0, 32'd3, 32'hA0, 0, t0);
    issue(2'd0, 32'd5, 32'hA1, 0, t1);
    issue(2'd0, 32'd7, 32'hA2, 0, t2);
    result(t2, valByTag[t2], 0);
    @(negedge clk);
    chk(!commitValid, "R4 head not ready", commitValid, 0);
    result(t0, valByTag[t0], 0);
    result(t1, valByTag[t1], 0);
    drain();

    // R6 store, R7 correctly predicted branch
    issue(2'd1, 32'h1000, 32'hBEEF, 0, t0);
    issue(2'd2, 32'd0, 32'h200, 0, t1);
    result(t1, valByTag[t1], 0);
    result(t0, valByTag[t0], 0);
    drain();

    // R3 stray result to an empty slot is ignored
    result(IDX_W'(expTail), 32'hDEAD, 0);
    issue(2'd0, 32'd9, 32'h55, 0, tx);
    @(negedge clk);
    chk(!commitValid, "R3 stray ignored", commitValid, 0);
    @(negedge clk);
    chk(!commitValid, "R3 stray ignored later", commitValid, 0);
    result(tx, valByTag[tx], 0);
    drain();

    // R2 fill to full with wrap, R9 slot reuse
    for (int i = 0; i < DEPTH; i++) issue(2'd0, DEST_W'(i + 16), DATA_W'(i * 3 + 1), 0, tg[i]);
    @(negedge clk);
    chk(robFull && !issueReady, "R2 full", {robFull, issueReady}, 2'b10);
    result(tg[0], valByTag[tg[0]], 0);
    @(negedge clk);
    @(negedge clk);
    chk(!robFull && issueReady, "R9 slot freed", {robFull, issueReady}, 2'b01);
    issue(2'd1, 32'h2000, 32'h77, 0, tx);
    chk(tx == tg[0], "R9 reuse freed slot", tx, tg[0]);
    for (int i = DEPTH - 1; i >= 1; i--) result(tg[i], valByTag[tg[i]], 0);
    result(tx, valByTag[tx], 0);
    drain();

    // R8 mispredicted branch flushes younger completed entries
    issue(2'd2, 32'd0, 32'h400, 1, tb);
    issue(2'd0, 32'd11, 32'h66, 0, t1);
    issue(2'd1, 32'h3000, 32'h67, 0, t2);
    result(t1, valByTag[t1], 0);
    result(t2, valByTag[t2], 0);
    result(tb, valByTag[tb], 1);
    @(negedge clk);
    @(negedge clk);
    chk(robEmpty && issueTag == 0, "R8 empty after flush", issueTag, 0);
    expTail = 0;
    repeat (5) @(negedge clk);
    chk(!commitValid, "R8 younger discarded", commitValid, 0);

    // after flush, dispatch restarts at tag 0
    issue(2'd0, 32'd2, 32'h99, 0, t0);
    result(t0, valByTag[t0], 0);
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule